// File: doc/BRIEF.md
# Programmable-Tap Transmit Scrambler

This block whitens a serial transmit bit stream with a self-synchronizing scrambler. Its memory is seven stages of past output bits. A seven-bit tap mask, held in a byte-wide configuration register, chooses which of those past bits feed the feedback parity. The feedback polynomial can therefore be changed at run time, with no change to the logic.

Each input bit arrives with a valid strobe. The block produces one scrambled bit per strobed clock, one cycle later. Idle cycles leave the scrambler memory untouched. A synchronous clear reseeds the memory to all ones. A mask of zero turns the block into a one-cycle delay line that passes data through unchanged.

Top module: `ptscr_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid` and `out_bit` are 0. Reset seeds the scrambler memory to all ones and sets the tap mask to zero.
- R2: `out_valid` is high in a cycle exactly when `in_valid` was high and `clr` was low in the previous cycle. `out_bit` keeps its last value in cycles when no bit is produced.
- R3: The scrambled bit is the input bit XORed with the parity of the memory bits whose mask bits are 1. Mask bit k (k = 0..6) selects the output that was produced k+1 strobed bits earlier.
- R4: On a strobed cycle the memory shifts left by one position and the new output bit enters position 0. On a cycle without the strobe the memory does not change.
- R5: With a tap mask of zero, every output bit equals the input bit that was presented one cycle earlier.
- R6: A write with `cfg_we` high and `cfg_addr` equal to 1Ch loads `cfg_wdata[6:0]` into the tap mask. `cfg_wdata[7]` is discarded. Writes to any other address leave the mask unchanged.
- R7: When `clr` is high, the memory is loaded with all ones on the next edge. A bit strobed in the same cycle is dropped, and no output is produced for it.
- R8: A mask write takes effect for bits strobed in the cycle after the write. A bit strobed in the same cycle as the write uses the old mask.
- R9: Mask value 48h gives the polynomial 1 + x^-4 + x^-7: y[n] = x[n] ^ y[n-4] ^ y[n-7].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| clr | input | 1 | Synchronous reseed of the scrambler memory to all ones |
| in_valid | input | 1 | Input bit strobe |
| in_bit | input | 1 | Serial input bit |
| out_valid | output | 1 | Output bit strobe, one cycle after `in_valid` |
| out_bit | output | 1 | Scrambled output bit |

## Verification
A wrong bit in the scrambler memory, or a wrong mask bit, shows up at `out_bit` on the first strobed bit whose feedback reads that position. With mask 48h this happens within seven strobed bits, because every position is shifted through a tap in that time. The error then feeds back into the memory and keeps corrupting later bits, so a bit-exact comparison on every cycle catches it within a few bits. Stalls, clears and writes that land in the same cycle as a strobe are exercised at the edges where a timing slip would shift the whole stream by one bit.

// File: rtl/ptscr_pkg.sv
`timescale 1ns/1ps
package ptscr_pkg;
    localparam int STAGES = 7;

    typedef logic [STAGES-1:0] tap_t;

    typedef struct packed {
        logic valid;
        logic dat;
    } sbit_t;

    localparam tap_t SEED = '1;

    function automatic logic tap_parity(tap_t mem, tap_t mask);
        return ^(mem & mask);
    endfunction
endpackage

// File: rtl/ptscr_tapreg.sv
`timescale 1ns/1ps
module ptscr_tapreg
    import ptscr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h1C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output tap_t              mask
);
    logic hit;
    assign hit = we && (addr == CFG_ADDR);

    always_ff @(posedge clk) begin
        if (rst)
            mask <= '0;
        else if (hit)
            mask <= wdata[STAGES-1:0];
    end

    a_r6_other_addr_ignored: assert property (@(posedge clk) disable iff (rst)
        !(we && addr == CFG_ADDR) |=> $stable(mask));
    a_r6_write_loads: assert property (@(posedge clk) disable iff (rst)
        (we && addr == CFG_ADDR) |=> mask == $past(wdata[STAGES-1:0]));
endmodule

// File: rtl/ptscr_core.sv
`timescale 1ns/1ps
module ptscr_core
    import ptscr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  sbit_t din,
    input  tap_t  mask,
    output sbit_t dout
);
    tap_t mem;
    logic fb_bit;
    logic scr_bit;

    assign fb_bit  = tap_parity(mem, mask);
    assign scr_bit = din.dat ^ fb_bit;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            mem <= SEED;
        end else if (din.valid) begin
            mem <= {mem[STAGES-2:0], scr_bit};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else begin
            dout.valid <= din.valid && !clr;
            if (din.valid && !clr)
                dout.dat <= scr_bit;
        end
    end

    a_r4_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (!din.valid && !clr) |=> $stable(mem));
    a_r4_shift_in: assert property (@(posedge clk) disable iff (rst)
        (din.valid && !clr) |=> (mem[STAGES-1:1] == $past(mem[STAGES-2:0])) && (mem[0] == dout.dat));
    a_r7_clear_seeds: assert property (@(posedge clk) disable iff (rst)
        clr |=> mem == SEED);
    a_r5_bypass: assert property (@(posedge clk) disable iff (rst)
        (din.valid && !clr && mask == '0) |=> dout.dat == $past(din.dat));
endmodule

// File: rtl/ptscr_top.sv
`timescale 1ns/1ps
module ptscr_top
    import ptscr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h1C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              clr,
    input  logic              in_valid,
    input  logic              in_bit,
    output logic              out_valid,
    output logic              out_bit
);
    tap_t  mask;
    sbit_t din;
    sbit_t dout;

    assign din.valid = in_valid;
    assign din.dat   = in_bit;

    ptscr_tapreg #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .CFG_ADDR(CFG_ADDR)
    ) u_tapreg (
        .clk  (clk),
        .rst  (rst),
        .we   (cfg_we),
        .addr (cfg_addr),
        .wdata(cfg_wdata),
        .mask (mask)
    );

    ptscr_core u_core (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .din (din),
        .mask(mask),
        .dout(dout)
    );

    assign out_valid = dout.valid;
    assign out_bit   = dout.dat;

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !clr) |=> out_valid);
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        (!in_valid || clr) |=> !out_valid);
    a_r2_bit_holds: assert property (@(posedge clk) disable iff (rst)
        (!in_valid || clr) |=> $stable(out_bit));
endmodule

// File: tb/test_ptscr_top.sv
`timescale 1ns/1ps
module test_ptscr_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_addr = 8'h00;
    logic [7:0] cfg_wdata = 8'h00;
    logic       clr = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_bit = 1'b0;
    logic       out_valid;
    logic       out_bit;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model: history of produced bits, newest first
    bit         hist[$];
    logic [6:0] m_mask;
    logic       e_valid;
    logic       e_bit;

    always #2.5 clk = ~clk;

    ptscr_top i_ptscr_top (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .clr(clr), .in_valid(in_valid),
        .in_bit(in_bit), .out_valid(out_valid), .out_bit(out_bit)
    );

    task automatic model_reset();
        hist.delete();
        for (int k = 0; k < 7; k++) hist.push_back(1'b1);
        m_mask  = 7'h00;
        e_valid = 1'b0;
        e_bit   = 1'b0;
    endtask

    task automatic expect_eq(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one clock: drive, advance model, check outputs at the following negedge
    task automatic cyc(string tag, logic v, logic b, logic c,
                       logic we, logic [7:0] a, logic [7:0] d);
        bit fb;
        in_valid = v; in_bit = b; clr = c;
        cfg_we = we; cfg_addr = a; cfg_wdata = d;
        e_valid = v && !c;
        if (c) begin
            for (int k = 0; k < 7; k++) hist[k] = 1'b1;
        end else if (v) begin
            fb = 1'b0;
            for (int k = 0; k < 7; k++) if (m_mask[k]) fb ^= hist[k];
            e_bit = b ^ fb;
            hist.push_front(e_bit);
            void'(hist.pop_back());
        end
        if (we && a == 8'h1C) m_mask = d[6:0];
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; clr = 1'b0; cfg_we = 1'b0;
        expect_eq(tag, "out_valid", out_valid, e_valid);
        expect_eq(tag, "out_bit", out_bit, e_bit);
    endtask

    task automatic wr(string tag, logic [7:0] a, logic [7:0] d);
        cyc(tag, 1'b0, 1'b0, 1'b0, 1'b1, a, d);
    endtask

    task automatic stream(string tag, int n, int stall_pct);
        for (int i = 0; i < n; i++) begin
            logic v;
            v = ($urandom_range(99) >= stall_pct);
            cyc(tag, v, 1'(($urandom) & 1), 1'b0, 1'b0, 8'h00, 8'h00);
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        expect_eq("R1", "out_valid in reset", out_valid, 1'b0);
        expect_eq("R1", "out_bit in reset", out_bit, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        expect_eq("R1", "out_valid after reset", out_valid, 1'b0);
        expect_eq("R1", "out_bit after reset", out_bit, 1'b0);

        // mask zero after reset: pass-through
        stream("R5", 24, 0);
        cyc("R2", 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);

        // write with bit 7 set: only bits 6:0 kept, giving 48h
        wr("R6", 8'h1C, 8'hC8);
        // writes elsewhere are ignored
        wr("R6", 8'h20, 8'h7F);
        wr("R6", 8'h1D, 8'h01);
        stream("R9", 80, 0);
        stream("R4", 60, 40);
        stream("R3", 40, 0);

        // clear mid-stream with a strobed bit that must be dropped
        cyc("R7", 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
        for (int i = 0; i < 16; i++) cyc("R7", 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);

        // mask change in the same cycle as a strobe uses the old mask
        cyc("R8", 1'b1, 1'b1, 1'b0, 1'b1, 8'h1C, 8'h7F);
        cyc("R8", 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        stream("R3", 40, 20);
        wr("R3", 8'h1C, 8'h01);
        stream("R3", 30, 10);
        wr("R3", 8'h1C, 8'h40);
        stream("R3", 30, 10);

        // only bit 7 written: mask becomes zero, bypass again
        wr("R6", 8'h1C, 8'h80);
        stream("R5", 30, 30);

        // clear with no strobe, then all-zero input under 48h
        wr("R9", 8'h1C, 8'h48);
        cyc("R7", 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00);
        for (int i = 0; i < 20; i++) cyc("R9", 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);

        // reset mid-run reseeds memory and clears mask
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        expect_eq("R1", "out_valid after re-reset", out_valid, 1'b0);
        stream("R1", 10, 0);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        end
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        end
        $finish;
    end
endmodule